// File: doc/BRIEF.md
# SAR ADC Conversion Sequencer

This block is the digital controller of a 10-bit successive-approximation converter. Software reaches it through a small byte-wide register port. Through that port it turns the converter on and picks an input channel. It also sets the length of the conversion clock period (TAD), sets an automatic acquisition time counted in TAD, and chooses how the result is aligned across two result bytes. The sample-and-hold, DAC, comparator and analog multiplexer sit outside the block. They appear here as a track/hold output, a DAC code output, a comparator input and a channel select output.

A conversion starts when the busy bit is written to 1 while the converter is on. The acquisition phase runs first, with the track output held high. A binary search follows. It spends one TAD on each result bit, from the MSB down, plus one closing TAD. At the end the busy bit drops, the result bytes load, and a completion flag is set. The flag drives the interrupt line when the interrupt is enabled. After every completed conversion the block rests for three TAD before a new acquisition can begin. A start written during that rest is held and runs once the rest is over.

Top module: `sar_adc_seq`

## Requirements
- R1: After reset, the control byte (address 0), the timing byte (address 1) and the interrupt byte (address 4) read 0x00, and `irq` and `sample_hold` are 0.
- R2: The control byte holds the channel in bits 5:2, busy/start in bit 1 and enable in bit 0, and bits 7:6 read 0. The timing byte holds the format in bit 7, the acquisition code in bits 5:3 and the clock code in bits 2:0, and bit 6 reads 0. `ch_sel` follows the channel field.
- R3: A start written while the enable bit stays 0 has no effect: busy reads 0 and `sample_hold` stays low.
- R4: With `cmp_in` high whenever the sampled input is at or above `dac_code`, the result equals the 10-bit input code.
- R5: After the register write that starts a conversion from idle, busy clears and the result loads exactly 1 + (n + 11)·D clock cycles later, where D is the TAD length in clocks and n the acquisition length in TAD.
- R6: D is set by the clock code: 000→2, 100→4, 001→8, 101→16, 010→32, 110→64, and 011 or 111→16.
- R7: n is set by the acquisition code: 0→0, 1→2, 2→4, 3→6, 4→8, 5→12, 6→16, 7→20. `sample_hold` is high for exactly n·D cycles, starting one cycle after the start write.
- R8: Format bit 1 gives address 2 = {000000, r[9:8]} and address 3 = r[7:0]. Format bit 0 gives address 2 = r[9:2] and address 3 = {r[1:0], 000000}.
- R9: Completion sets the flag (address 4 bit 0), and `irq` = flag AND interrupt enable (address 4 bit 1). Writing 0 to bit 0 clears the flag, and writing 1 to it leaves the flag unchanged.
- R10: A start written right after completion begins acquisition only once 3 TAD have passed since completion, and then converts normally.
- R11: Writing the enable bit to 0 during a conversion ends it at once: busy clears, `sample_hold` drops, the result bytes are unchanged and the flag stays clear.
- R12: Writing start again while busy does not restart or delay the running conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 control, 1 timing, 2 result high, 3 result low, 4 interrupt) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from address) |
| cmp_in | input | 1 | Comparator: 1 when sampled input ≥ DAC output |
| dac_code | output | 10 | Trial code for the external DAC |
| sample_hold | output | 1 | High while the sample-and-hold tracks (acquisition) |
| ch_sel | output | 4 | Analog channel select |
| irq | output | 1 | Interrupt request |

## Verification
Every conversion is timed from the edge that registers the start write. The bench waits exactly (n + 11)·D edges and confirms busy is still 1. It then steps one more edge and confirms busy is 0, `irq` is 1 and the result bytes are correct. It counts the `sample_hold` cycles over the same window, so R5, R6 and R7 are checked to the cycle. The rest period is checked the same way: track must be low at every sample until the edge 3·D + 1 after completion, and high at that edge. All outputs are sampled on the falling edge, half a cycle after the register that drives them updates.

// File: rtl/sar_adc_seq.sv
`timescale 1ns/100ps
module sar_adc_seq #(
  parameter int RES_W     = 10,
  parameter int GUARD_TAD = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             cmp_in,
  output logic [RES_W-1:0] dac_code,
  output logic             sample_hold,
  output logic [3:0]       ch_sel,
  output logic             irq
);
  localparam int CONV_TAD = RES_W + 1;
  localparam int STEP_MAX = (CONV_TAD > 20) ? CONV_TAD : 20;
  localparam int STEP_W   = $clog2(STEP_MAX + 1);
  localparam int PAD_W    = 16 - RES_W;

  typedef enum logic [1:0] {S_IDLE, S_ACQ, S_CONV, S_GUARD} state_t;

  state_t            state;
  logic              en, go, fmt, flag, ien;
  logic [3:0]        ch;
  logic [2:0]        acq, cks;
  logic [7:0]        res_hi, res_lo;
  logic [5:0]        tcnt;
  logic [STEP_W-1:0] step;
  logic [RES_W-1:0]  acc, trial;
  logic [15:0]       packed_res;
  logic              unused_wbits;

  function automatic logic [6:0] tad_div(input logic [2:0] s);
    case (s)
      3'b000:  return 7'd2;
      3'b001:  return 7'd8;
      3'b010:  return 7'd32;
      3'b100:  return 7'd4;
      3'b101:  return 7'd16;
      3'b110:  return 7'd64;
      default: return 7'd16;
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] acq_len(input logic [2:0] a);
    case (a)
      3'd0:    return STEP_W'(0);
      3'd1:    return STEP_W'(2);
      3'd2:    return STEP_W'(4);
      3'd3:    return STEP_W'(6);
      3'd4:    return STEP_W'(8);
      3'd5:    return STEP_W'(12);
      3'd6:    return STEP_W'(16);
      default: return STEP_W'(20);
    endcase
  endfunction

  wire [6:0]        div   = tad_div(cks);
  wire [STEP_W-1:0] n_acq = acq_len(acq);
  wire              tick  = ({1'b0, tcnt} == div - 7'd1);
  wire              wr0   = reg_we && reg_addr == 3'd0;
  wire              wr1   = reg_we && reg_addr == 3'd1;
  wire              wr4   = reg_we && reg_addr == 3'd4;
  wire              abort = wr0 && !reg_wdata[0];
  wire              done  = state == S_CONV && tick && step == STEP_W'(CONV_TAD - 1);

  assign unused_wbits = reg_wdata[6];

  always_comb begin
    trial = '0;
    if (state == S_CONV && step < STEP_W'(RES_W))
      trial[RES_W - 1 - int'(step)] = 1'b1;
  end

  assign packed_res  = fmt ? {{PAD_W{1'b0}}, acc} : {acc, {PAD_W{1'b0}}};
  assign dac_code    = acc | trial;
  assign sample_hold = state == S_ACQ;
  assign ch_sel      = ch;
  assign irq         = flag & ien;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {2'b00, ch, go, en};
      3'd1:    reg_rdata = {fmt, 1'b0, acq, cks};
      3'd2:    reg_rdata = res_hi;
      3'd3:    reg_rdata = res_lo;
      3'd4:    reg_rdata = {6'd0, ien, flag};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; go <= 1'b0; ch <= '0;
      fmt <= 1'b0; acq <= '0; cks <= '0;
      flag <= 1'b0; ien <= 1'b0;
    end else begin
      if (wr0) begin
        ch <= reg_wdata[5:2];
        en <= reg_wdata[0];
      end
      if (wr1) begin
        fmt <= reg_wdata[7];
        acq <= reg_wdata[5:3];
        cks <= reg_wdata[2:0];
      end
      if (wr4) ien <= reg_wdata[1];

      if (abort)                          go <= 1'b0;
      else if (wr0 && reg_wdata[1])       go <= 1'b1;
      else if (done)                      go <= 1'b0;

      if (done)                           flag <= 1'b1;
      else if (wr4 && !reg_wdata[0])      flag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; tcnt <= '0; step <= '0; acc <= '0;
      res_hi <= '0; res_lo <= '0;
    end else if (abort) begin
      state <= S_IDLE; tcnt <= '0; step <= '0;
    end else if (state == S_IDLE) begin
      tcnt <= '0;
      step <= '0;
      if (go) begin
        acc   <= '0;
        state <= (n_acq == '0) ? S_CONV : S_ACQ;
      end
    end else begin
      tcnt <= tick ? 6'd0 : tcnt + 6'd1;
      if (tick) begin
        case (state)
          S_ACQ: begin
            if (step == n_acq - STEP_W'(1)) begin
              state <= S_CONV;
              step  <= '0;
            end else step <= step + STEP_W'(1);
          end
          S_CONV: begin
            if (cmp_in) acc <= acc | trial;
            if (done) begin
              state  <= S_GUARD;
              step   <= '0;
              res_hi <= packed_res[15:8];
              res_lo <= packed_res[7:0];
            end else step <= step + STEP_W'(1);
          end
          S_GUARD: begin
            if (step == STEP_W'(GUARD_TAD - 1)) begin
              state <= S_IDLE;
              step  <= '0;
            end else step <= step + STEP_W'(1);
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/sar_adc_seq_chk.sv
`timescale 1ns/100ps
module sar_adc_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       go,
  input logic       flag,
  input logic       sample_hold,
  input logic [7:0] res_hi,
  input logic [7:0] res_lo
);
  a_r3_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !go);

  a_r7_track_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    sample_hold |-> go);

  a_r9_flag_rises_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(go));

  a_r9_finish_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(go) && en) |-> flag);

  a_r11_result_moves_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (res_hi != $past(res_hi) || res_lo != $past(res_lo)) |-> flag);
endmodule

bind sar_adc_seq sar_adc_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .go(go), .flag(flag),
  .sample_hold(sample_hold), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/sim_sar_adc_seq.sv
`timescale 1ns/100ps
module sim_sar_adc_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       cmp_in;
  logic [9:0] dac_code;
  logic       sample_hold;
  logic [3:0] ch_sel;
  logic       irq;
  logic [9:0] vin = '0;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;
  assign cmp_in = (vin >= dac_code);

  sar_adc_seq u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmp_in(cmp_in),
    .dac_code(dac_code), .sample_hold(sample_hold), .ch_sel(ch_sel), .irq(irq)
  );

  function automatic int d_of(input logic [2:0] c);
    case (c)
      3'b000: return 2;   3'b100: return 4;
      3'b001: return 8;   3'b101: return 16;
      3'b010: return 32;  3'b110: return 64;
      default: return 16;
    endcase
  endfunction

  function automatic int n_of(input logic [2:0] a);
    case (a)
      3'd0: return 0;  3'd1: return 2;  3'd2: return 4;  3'd3: return 6;
      3'd4: return 8;  3'd5: return 12; 3'd6: return 16; default: return 20;
    endcase
  endfunction

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    reg_addr = a;
    #0.1;
    d = reg_rdata;
  endtask

  task automatic chk_result(input bit fmt, input logic [9:0] v, input string tag);
    logic [7:0] hi, lo;
    rd(3'd2, hi); rd(3'd3, lo);
    chk(hi, fmt ? {6'd0, v[9:8]} : v[9:2], {tag, " R4 R8 high byte"});
    chk(lo, fmt ? v[7:0] : {v[1:0], 6'd0}, {tag, " R4 R8 low byte"});
  endtask

  task automatic run_conv(input logic [2:0] cks, input logic [2:0] acq, input bit fmt,
                          input logic [9:0] v, input logic [3:0] ch, input bit restart);
    int d = d_of(cks);
    int n = n_of(acq);
    int k = (n + 11) * d;
    int sh = 0;
    logic [7:0] r;
    vin = v;
    wr(3'd1, {fmt, 1'b0, acq, cks});
    wr(3'd4, 8'h02);
    wr(3'd0, {2'b00, ch, 2'b11});
    if (restart) begin
      wr(3'd0, {2'b00, ch, 2'b11});
      if (sample_hold) sh++;
      k = k - 1;
    end
    for (int i = 0; i < k; i++) begin
      @(negedge clk);
      if (sample_hold) sh++;
    end
    chk(sh, n * d, "R7 track cycles");
    rd(3'd0, r);
    chk(r[1], 1, restart ? "R12 busy before due edge" : "R5 R6 busy before due edge");
    @(negedge clk);
    rd(3'd0, r);
    chk(r, {2'b00, ch, 2'b01}, restart ? "R12 busy cleared on time" : "R5 R6 busy cleared on time");
    chk(irq, 1, "R9 irq at completion");
    chk_result(fmt, v, "conversion");
    repeat (3 * d) @(negedge clk);
  endtask

  initial begin
    #(150000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog expired: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    int sh;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(3'd0, r); chk(r, 8'h00, "R1 control byte");
    rd(3'd1, r); chk(r, 8'h00, "R1 timing byte");
    rd(3'd4, r); chk(r, 8'h00, "R1 interrupt byte");
    chk(irq, 0, "R1 irq");
    chk(sample_hold, 0, "R1 sample_hold");

    // R2 field layout
    wr(3'd0, 8'hC0 | (8'd9 << 2));
    rd(3'd0, r); chk(r, 8'd9 << 2, "R2 control readback");
    chk(ch_sel, 9, "R2 ch_sel");
    wr(3'd1, 8'hFF);
    rd(3'd1, r); chk(r, 8'hBF, "R2 timing readback");
    wr(3'd1, 8'h00);

    // R3 start without enable
    wr(3'd0, 8'h02 | (8'd3 << 2));
    sh = 0;
    repeat (30) begin @(negedge clk); if (sample_hold) sh++; end
    rd(3'd0, r); chk(r, 8'd3 << 2, "R3 busy stays clear");
    chk(sh, 0, "R3 no acquisition");

    // R6 clock codes, R7 acquisition codes
    for (int c = 0; c < 8; c++)
      run_conv(3'(c), 3'd1, c[0], 10'(37 * c + 101), 4'(c), 1'b0);
    for (int a = 0; a < 8; a++)
      run_conv(3'd0, 3'(a), a[0], 10'(1023 - 55 * a), 4'(a + 5), 1'b0);

    // R4 R8 full code sweep
    for (int v = 0; v < 1024; v++)
      run_conv(3'd0, 3'd0, v[0] ^ v[5], 10'(v), 4'(v % 13), 1'b0);

    // R12 restart while busy
    run_conv(3'd4, 3'd0, 1'b1, 10'h2A5, 4'd2, 1'b1);

    // R9 flag clear and irq gating
    rd(3'd4, r); chk(r, 8'h03, "R9 flag and enable set");
    wr(3'd4, 8'h01);
    chk(irq, 0, "R9 irq masked");
    rd(3'd4, r); chk(r, 8'h01, "R9 write 1 keeps flag");
    wr(3'd4, 8'h00);
    rd(3'd4, r); chk(r, 8'h00, "R9 write 0 clears flag");

    // R10 rest period after completion
    begin
      int k = (n_of(3'd1) + 11) * 2;
      vin = 10'h155;
      wr(3'd1, {1'b1, 1'b0, 3'd1, 3'd0});
      wr(3'd4, 8'h02);
      wr(3'd0, 8'h03);
      repeat (k) @(negedge clk);
      @(negedge clk);
      rd(3'd0, r); chk(r[1], 0, "R10 first conversion done");
      wr(3'd0, 8'h03);
      for (int j = 2; j <= 7; j++) begin
        @(negedge clk);
        chk(sample_hold, (j == 7) ? 1 : 0, "R10 track held off for rest period");
      end
      vin = 10'h0CA;
      repeat (k - 1) @(negedge clk);
      rd(3'd0, r); chk(r[1], 1, "R10 second conversion busy");
      @(negedge clk);
      rd(3'd0, r); chk(r[1], 0, "R10 second conversion done");
      chk_result(1'b1, 10'h0CA, "R10");
      repeat (6) @(negedge clk);
    end

    // R11 abort
    wr(3'd4, 8'h02);
    vin = 10'h3F0;
    wr(3'd1, {1'b0, 1'b0, 3'd2, 3'd0});
    wr(3'd0, 8'h03);
    repeat (12) @(negedge clk);
    chk(sample_hold, 0, "R11 in search phase before abort");
    wr(3'd0, 8'h00);
    rd(3'd0, r); chk(r, 8'h00, "R11 busy cleared by abort");
    chk(sample_hold, 0, "R11 track low after abort");
    repeat (60) @(negedge clk);
    rd(3'd4, r); chk(r, 8'h02, "R11 flag stays clear");
    chk(irq, 0, "R11 no irq");
    chk_result(1'b1, 10'h0CA, "R11 unchanged");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule